// File: doc/BRIEF.md
# Debounced Input Interrupt Bank

This block takes a vector of external input lines, resynchronises them, and filters each line through its own millisecond debounce timer. Each channel has its own timer. A filtered level is accepted only after the raw input has held a new value for the programmed number of consecutive millisecond ticks. Software reads the filtered levels through a small 32-bit register bus. It chooses per channel whether the level is visible.

Each channel can raise a level interrupt of selectable polarity. Detection is single-shot. A channel is armed by writing its trigger-start bit. It records at most one event, then waits until software arms it again. Raw status bits are cleared by writing 1. The masked status is the raw status gated by the interrupt enables, and all masked bits are combined into one interrupt line.

The bus has no wait states. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`.

Top module: `dbnc_irq_bank`

## Requirements
- R1: After reset every register reads 0 and `irq_out` is 0. The registers are: data 0x00, read-enable 0x04, polarity 0x14, interrupt enable 0x18, raw status 0x1C, masked status 0x20 and the control words.
- R2: A channel's filtered level takes the new input value on the P-th consecutive `ms_tick` during which the resynchronised input differs from it, and not before. P is the 12-bit period in bits [11:0] of that channel's control word. The input passes through two synchroniser flops first.
- R3: If the input returns to the filtered level before P ticks have elapsed, the tick count restarts from zero.
- R4: A period of 0 behaves exactly like a period of 1.
- R5: The control word of channel n sits at 0x40 + 4·n. All 32 bits read back as written, and the largest period, 4095, is honoured.
- R6: Bit n of the data register (0x00) shows the filtered level of channel n only when bit n of the read-enable register (0x04) is 1. Otherwise that bit reads 0.
- R7: Polarity bit n (0x14) set to 1 makes a high filtered level active; set to 0 it makes a low level active. An armed channel whose level is active sets its raw status bit (0x1C). An armed channel whose level is inactive stays armed without setting it.
- R8: Writing 1 to bit n of 0x28 arms channel n. Once the channel sets its raw bit it is disarmed, and it records no new event until armed again, even while its level stays active. A channel that was never armed sets no raw bit.
- R9: Writing 1 to bit n of 0x24 clears raw status bit n. Registers 0x24 and 0x28 read as 0.
- R10: The masked status (0x20) equals raw status AND interrupt enable (0x18). `irq_out` is 1 exactly when any masked status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NCH (8) | Asynchronous external inputs |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| bus_rd | input | 1 | Read strobe (read data is valid whenever the address is) |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | OR of all masked status bits |

## Verification
On every cycle the assertions check three things. A filtered level moves only in the cycle after a millisecond tick. A raw status bit can rise only from a channel that was armed one cycle earlier. A clear write on a disarmed channel always leaves its bit low. They also check that the combined line stays low while every enable is off. The bench scenarios cover the rest: the exact tick count at which each period accepts a new level, count restart on a glitch, and the treatment of a zero period. They also cover read gating and polarity selection, the single-shot re-arm sequence, and the full 12-bit period boundary.

// File: rtl/dbi_pkg.sv
// Shared register offsets for the debounced interrupt bank.
// Assumes byte addressing with 32-bit aligned registers.
package dbi_pkg;
    localparam int OFS_DATA  = 'h00;
    localparam int OFS_RDEN  = 'h04;
    localparam int OFS_POL   = 'h14;
    localparam int OFS_IEN   = 'h18;
    localparam int OFS_RAW   = 'h1C;
    localparam int OFS_MSK   = 'h20;
    localparam int OFS_CLR   = 'h24;
    localparam int OFS_TRIG  = 'h28;
    localparam int OFS_CTRL0 = 'h40;
    localparam int DW        = 32;
endpackage

// File: rtl/dbi_sync.sv
// Two-flop resynchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no grey coding across bits.
module dbi_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the inputs through two flops, clearing both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dbi_filter.sv
// Debounce filter for one channel: the output follows the input only
// after the input has differed from it for PERIOD consecutive ticks.
// Assumes din is already synchronous; a period of 0 is handled as 1.
module dbi_filter #(
    parameter int TIMW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din,
    input  logic            tick,
    input  logic [TIMW-1:0] period,
    output logic            filt
);
    logic [TIMW-1:0] cnt;
    logic [TIMW-1:0] eff_period;
    logic [TIMW:0]   cnt_inc;

    // Substitute 1 for a zero period and form the next count.
    always_comb begin
        eff_period = (period == '0) ? TIMW'(1) : period;
        cnt_inc    = {1'b0, cnt} + (TIMW+1)'(1);
    end

    // Count ticks while the input disagrees; accept at the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            filt <= 1'b0;
        end else if (din == filt) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt_inc >= {1'b0, eff_period}) begin
                filt <= din;
                cnt  <= '0;
            end else begin
                cnt <= cnt_inc[TIMW-1:0];
            end
        end
    end
endmodule

// File: rtl/dbi_event.sv
// Single-shot level event capture for all channels.
// A channel arms on a trigger bit, fires once when its level is active,
// then stays disarmed. Trigger wins over a same-cycle fire, and a new
// event wins over a same-cycle clear.
module dbi_event #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] filt,
    input  logic [NCH-1:0] pol,
    input  logic [NCH-1:0] trig_vec,
    input  logic [NCH-1:0] clr_vec,
    output logic [NCH-1:0] raw,
    output logic [NCH-1:0] armed
);
    logic [NCH-1:0] fire;

    // A channel fires when it is armed and its level matches its polarity.
    always_comb begin
        fire = armed & ~(filt ^ pol);
    end

    // Update the arm flags and raw status from fire, trigger and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= '0;
            raw   <= '0;
        end else begin
            armed <= (armed & ~fire) | trig_vec;
            raw   <= (raw & ~clr_vec) | fire;
        end
    end
endmodule

// File: rtl/dbi_regs.sv
// Register file of the bank: read-enable, polarity, interrupt enable and
// per-channel control words, plus write pulses for clear and trigger, and
// the combinational read mux. Assumes single-cycle, zero-wait accesses.
module dbi_regs
    import dbi_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int AW   = 8,
    parameter int TIMW = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [AW-1:0]             bus_addr,
    input  logic [DW-1:0]             bus_wdata,
    output logic [DW-1:0]             bus_rdata,
    input  logic [NCH-1:0]            filt,
    input  logic [NCH-1:0]            raw,
    output logic [NCH-1:0]            pol_q,
    output logic [NCH-1:0]            ien_q,
    output logic [NCH-1:0]            trig_vec,
    output logic [NCH-1:0]            clr_vec,
    output logic [NCH-1:0][TIMW-1:0]  period
);
    localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);
    localparam logic [AW-1:0] A_RDEN = AW'(OFS_RDEN);
    localparam logic [AW-1:0] A_POL  = AW'(OFS_POL);
    localparam logic [AW-1:0] A_IEN  = AW'(OFS_IEN);
    localparam logic [AW-1:0] A_RAW  = AW'(OFS_RAW);
    localparam logic [AW-1:0] A_MSK  = AW'(OFS_MSK);
    localparam logic [AW-1:0] A_CLR  = AW'(OFS_CLR);
    localparam logic [AW-1:0] A_TRIG = AW'(OFS_TRIG);

    logic [NCH-1:0]         rden_q;
    logic [DW-1:0]          ctrl_q [NCH];
    logic [NCH-1:0]         ctrl_hit;

    // Decode one write-select line per control word.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ctrl_hit[i] = (bus_addr == AW'(OFS_CTRL0 + 4*i));
        end
    end

    // Form one-cycle clear and trigger pulses from bus writes.
    always_comb begin
        trig_vec = (bus_wr && bus_addr == A_TRIG) ? bus_wdata[NCH-1:0] : '0;
        clr_vec  = (bus_wr && bus_addr == A_CLR)  ? bus_wdata[NCH-1:0] : '0;
    end

    // Hold the per-bank configuration bit vectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rden_q <= '0;
            pol_q  <= '0;
            ien_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_RDEN) rden_q <= bus_wdata[NCH-1:0];
            if (bus_addr == A_POL)  pol_q  <= bus_wdata[NCH-1:0];
            if (bus_addr == A_IEN)  ien_q  <= bus_wdata[NCH-1:0];
        end
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ctrl
            // Hold one full control word per channel.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctrl_q[g] <= '0;
                end else if (bus_wr && ctrl_hit[g]) begin
                    ctrl_q[g] <= bus_wdata;
                end
            end
            assign period[g] = ctrl_q[g][TIMW-1:0];
        end
    endgenerate

    // Select read data for the current address.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DATA:  bus_rdata[NCH-1:0] = filt & rden_q;
            A_RDEN:  bus_rdata[NCH-1:0] = rden_q;
            A_POL:   bus_rdata[NCH-1:0] = pol_q;
            A_IEN:   bus_rdata[NCH-1:0] = ien_q;
            A_RAW:   bus_rdata[NCH-1:0] = raw;
            A_MSK:   bus_rdata[NCH-1:0] = raw & ien_q;
            default: bus_rdata = '0;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (ctrl_hit[i]) bus_rdata = ctrl_q[i];
        end
    end
endmodule

// File: rtl/dbnc_irq_bank.sv
// Top of the debounced input interrupt bank: synchroniser, one debounce
// filter per channel, single-shot event capture and register file.
// Assumes ms_tick is a one-cycle pulse in the clk domain.
module dbnc_irq_bank #(
    parameter int NCH  = 8,
    parameter int AW   = 8,
    parameter int TIMW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_in,
    input  logic           ms_tick,
    input  logic           bus_rd,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           irq_out
);
    logic [NCH-1:0]           sync_w;
    logic [NCH-1:0]           filt_w;
    logic [NCH-1:0]           raw_w;
    logic [NCH-1:0]           armed_w;
    logic [NCH-1:0]           pol_w;
    logic [NCH-1:0]           ie_w;
    logic [NCH-1:0]           trig_w;
    logic [NCH-1:0]           clr_w;
    logic [NCH-1:0][TIMW-1:0] period_w;
    logic                     rd_unused;

    // Read strobe is accepted but the read path needs no side effect.
    assign rd_unused = bus_rd;

    dbi_sync #(.W(NCH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_w)
    );

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_flt
            dbi_filter #(.TIMW(TIMW)) u_flt (
                .clk    (clk),
                .rst_n  (rst_n),
                .din    (sync_w[g]),
                .tick   (ms_tick),
                .period (period_w[g]),
                .filt   (filt_w[g])
            );
        end
    endgenerate

    dbi_event #(.NCH(NCH)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .filt     (filt_w),
        .pol      (pol_w),
        .trig_vec (trig_w),
        .clr_vec  (clr_w),
        .raw      (raw_w),
        .armed    (armed_w)
    );

    dbi_regs #(.NCH(NCH), .AW(AW), .TIMW(TIMW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .filt      (filt_w),
        .raw       (raw_w),
        .pol_q     (pol_w),
        .ien_q     (ie_w),
        .trig_vec  (trig_w),
        .clr_vec   (clr_w),
        .period    (period_w)
    );

    // Combine every enabled raw status bit into the interrupt line.
    always_comb begin
        irq_out = |(raw_w & ie_w);
    end
endmodule

// File: rtl/dbi_checker.sv
// Property checker for the debounced interrupt bank, bound to the top.
module dbi_checker #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ms_tick,
    input logic [NCH-1:0] filt,
    input logic [NCH-1:0] raw,
    input logic [NCH-1:0] armed,
    input logic [NCH-1:0] ie,
    input logic [NCH-1:0] clr_vec,
    input logic           irq_out
);
    AST_FILT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> $past(ms_tick)); // R2

    AST_RAW_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & ~$past(raw) & ~$past(armed)) == '0); // R8

    AST_CLR_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & $past(clr_vec) & ~$past(armed)) == '0); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == '0) |-> !irq_out); // R10
endmodule

bind dbnc_irq_bank dbi_checker #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick),
    .filt    (filt_w),
    .raw     (raw_w),
    .armed   (armed_w),
    .ie      (ie_w),
    .clr_vec (clr_w),
    .irq_out (irq_out)
);

// File: tb/dbnc_irq_bank_tb.sv
module dbnc_irq_bank_tb;
    localparam int NCH = 8;
    localparam int AW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pin_in = '0;
    logic           ms_tick = 1'b0;
    logic           bus_rd = 1'b0;
    logic           bus_wr = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           irq_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dbnc_irq_bank #(.NCH(NCH), .AW(AW), .TIMW(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ms_tick(ms_tick),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // Fields: [31:28] channel, [27:16] period, [15:4] ticks, [0] expect accept
    localparam bit [31:0] TBL [8] = '{
        32'h00030020, 32'h00030031, 32'h10000011, 32'h20010011,
        32'h30050040, 32'h30050061, 32'h700A00A1, 32'h50020010
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(8'h00, v); check("R1 data", v, 0);
        rd(8'h04, v); check("R1 rden", v, 0);
        rd(8'h14, v); check("R1 pol", v, 0);
        rd(8'h18, v); check("R1 ien", v, 0);
        rd(8'h1C, v); check("R1 raw", v, 0);
        rd(8'h20, v); check("R1 msk", v, 0);
        rd(8'h44, v); check("R1 ctrl1", v, 0);
        check("R1 irq", {31'd0, irq_out}, 0);

        wr(8'h04, 32'hFF);
        // Table walk: R2 accept count, R4 zero period
        foreach (TBL[k]) begin
            int ch, per, tk, eff;
            bit fl;
            ch = int'(TBL[k][31:28]); per = int'(TBL[k][27:16]);
            tk = int'(TBL[k][15:4]); fl = TBL[k][0];
            eff = (per == 0) ? 1 : per;
            wr(8'(8'h40 + 4*ch), 32'(per));
            @(negedge clk); pin_in[ch] = 1'b1;
            idle(3);
            ticks(tk);
            rd(8'h00, v);
            check(per == 0 ? "R4 zero period" : "R2 accept", {31'd0, v[ch]}, {31'd0, fl});
            @(negedge clk); pin_in[ch] = 1'b0;
            idle(3);
            if (fl) ticks(eff);
            rd(8'h00, v);
            check("R2 return", v, 0);
        end

        // R3 restart on glitch (ch4, period 4)
        wr(8'h50, 32'd4);
        @(negedge clk); pin_in[4] = 1'b1; idle(3);
        ticks(3);
        @(negedge clk); pin_in[4] = 1'b0; idle(3);
        @(negedge clk); pin_in[4] = 1'b1; idle(3);
        ticks(3);
        rd(8'h00, v); check("R3 restarted", v, 0);
        ticks(1);
        rd(8'h00, v); check("R3 accept", v, 32'h10);

        // R6 data gating
        wr(8'h04, 32'h01);
        rd(8'h00, v); check("R6 gated", v, 0);
        wr(8'h04, 32'h10);
        rd(8'h00, v); check("R6 visible", v, 32'h10);

        // R8 no event before arming, R7 polarity high
        wr(8'h14, 32'h50);
        idle(2);
        rd(8'h1C, v); check("R8 unarmed", v, 0);
        wr(8'h18, 32'h10);
        wr(8'h28, 32'h10);
        idle(2);
        rd(8'h1C, v); check("R7 high active", v, 32'h10);
        rd(8'h20, v); check("R10 msk", v, 32'h10);
        check("R10 irq on", {31'd0, irq_out}, 1);
        rd(8'h24, v); check("R9 clr reads 0", v, 0);
        rd(8'h28, v); check("R9 trig reads 0", v, 0);
        wr(8'h24, 32'h10);
        idle(3);
        rd(8'h1C, v); check("R8 single shot", v, 0);
        check("R10 irq off", {31'd0, irq_out}, 0);
        wr(8'h28, 32'h10);
        idle(2);
        rd(8'h1C, v); check("R8 rearm", v, 32'h10);
        wr(8'h24, 32'h10);
        idle(1);
        rd(8'h1C, v); check("R9 clear", v, 0);

        // R7 low polarity on ch5, R10 masked by enable
        wr(8'h28, 32'h20);
        idle(2);
        rd(8'h1C, v); check("R7 low active", v, 32'h20);
        rd(8'h20, v); check("R10 masked off", v, 0);
        check("R10 irq masked", {31'd0, irq_out}, 0);
        wr(8'h24, 32'h20);

        // R7 armed but inactive (ch6 high polarity, level low)
        wr(8'h28, 32'h40);
        idle(2);
        rd(8'h1C, v); check("R7 inactive", v, 0);
        wr(8'h58, 32'd1);
        @(negedge clk); pin_in[6] = 1'b1; idle(3);
        ticks(1);
        idle(2);
        rd(8'h1C, v); check("R7 fires when active", v, 32'h40);

        // R5 full word readback and maximum period on ch2
        wr(8'h48, 32'hABCDEFFF);
        rd(8'h48, v); check("R5 readback", v, 32'hABCDEFFF);
        wr(8'h04, 32'h04);
        @(negedge clk); pin_in[2] = 1'b1; idle(3);
        ticks(4094);
        rd(8'h00, v); check("R5 max minus one", v, 0);
        ticks(1);
        rd(8'h00, v); check("R5 max period", v, 32'h04);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule